// File: doc/BRIEF.md
# Interleaved Multiphase PWM Sequencer

This block controls up to four interleaved PWM phases for a multiphase buck regulator. It drives logic-level outputs to external gate drivers. When enable rises, a two-cycle probe window opens. During the window the third and fourth phase pins are held at a mid-level sense state, and each pin reports through a digital comparator input whether it is tied to ground. The block latches the resulting phase count (four, three or two) and raises a ready flag. From the next period boundary it runs each populated phase from one shared period counter.

Phase k starts its period at floor(k·P/N) ticks, where P is the programmed period and N is the detected count. This spreads the active phases evenly across the period in order 1, 2, 3, 4. Each phase has its own duty word and is decoded on its own, so outputs may overlap and a phase may stay on for all but one tick of its period. Every clock cycle is one master tick.

The state machine has five states. OFF is the idle state. PROBE_A and PROBE_B form the probe window. ALIGN waits for the period boundary. RUN is the switching state. The transitions are:
- OFF→PROBE_A when enable is seen high.
- PROBE_A→PROBE_B after one tick.
- PROBE_B→ALIGN after one tick; the phase count is latched on this step.
- ALIGN→RUN when the counter wraps.
- Any state→OFF when enable is low.

Top module: `pwm_phase_sequencer`

## Requirements
- R1: While reset is held, and after reset with enable low, all PWM outputs, both probe flags, ready and the phase-count code are 0.
- R2: For exactly the first two cycles after enable is seen high, `pwm_probe` is 2'b11 (bit 0 = phase 3 pin, bit 1 = phase 4 pin), every PWM output is low and ready is low.
- R3: The count is taken from `sense_lo` as sampled in the second probe cycle. Bit 0 high (phase 3 grounded) gives two phases regardless of bit 1. Only bit 1 high gives three phases. Neither high gives four. `phase_cnt` reports count−1: 2'b01, 2'b10 or 2'b11.
- R4: From the third cycle after enable, ready is high and `phase_cnt` is valid. All outputs stay low until the period counter, which is 0 in the first probe cycle, wraps from P−1 to 0. At that point switching begins.
- R5: In RUN, with period count c, phase k (k = 0..N−1) is high while (c − floor(k·P/N)) mod P < duty_k.
- R6: A duty word of P or more acts as P−1. A duty of 0 keeps the phase low.
- R7: Phases with index N or higher stay low for as long as enable stays high.
- R8: Changes on `sense_lo` after the probe window do not alter the count or the outputs.
- R9: One cycle after enable is seen low, all outputs, ready and the code are 0. Enabling again repeats the probe window from the start.
- R10: A programmed period below 4 acts as 4.
- R11: Several phase outputs may be high in the same cycle when their on-windows overlap.
- R12: In the first period after entering RUN, phase k stays low until the count first reaches its start offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one tick per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enable; low forces idle and clears the count |
| period | input | CNT_W | Period length P in ticks (minimum 4) |
| duty | input | 4·CNT_W | Duty words, phase k in bits [k·CNT_W +: CNT_W] |
| sense_lo | input | 2 | Below-threshold flags of the phase 3 / phase 4 pins |
| pwm_out | output | 4 | Logic-level gate-drive outputs, bit k = phase k+1 |
| pwm_probe | output | 2 | Phase 3 / phase 4 pins held at sense level |
| ready | output | 1 | Detection complete |
| phase_cnt | output | 2 | Detected count − 1, 0 while not ready |

## Verification
The scoreboard goes after three kinds of corner case:
- Probe-window timing. Ending the window a cycle early or late moves ready and the probe flags by one cycle against the expected stream.
- Phase-count decoding. Swapping or reading the sense bits in the wrong order, or leaving them open after the window, gives a wrong code or lets a disabled phase switch.
- Switching edges. An offset computed from the wrong count, a missing duty clamp, a period below 4 not treated as 4, or an output raised before its first start in the opening period all put pulses on the wrong ticks.

An enable drop in the middle of the probe window, followed by a new case, shows whether the latched count and the counter are cleared.

// File: rtl/pss_pkg.sv
package pss_pkg;
    localparam int MAX_PH     = 4;
    localparam int SENSED     = 2;
    localparam int MIN_PERIOD = 4;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PROBE_A,
        ST_PROBE_B,
        ST_ALIGN,
        ST_RUN
    } seq_state_t;

    typedef enum logic [1:0] {
        PC_NONE  = 2'b00,
        PC_TWO   = 2'b01,
        PC_THREE = 2'b10,
        PC_FOUR  = 2'b11
    } ph_code_t;
endpackage

// File: rtl/pss_period_ctr.sv
module pss_period_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] len,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    assign wrap = (cnt >= len - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/pss_offset_gen.sv
module pss_offset_gen
    import pss_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0]        len,
    input  ph_code_t                code,
    output logic [MAX_PH*CNT_W-1:0] offsets
);
    localparam int PW = CNT_W + 2;

    for (genvar k = 0; k < MAX_PH; k++) begin : g_off
        logic [PW-1:0] prod;
        logic [PW-1:0] quot;

        assign prod = PW'(k) * PW'(len);

        always_comb begin
            unique case (code)
                PC_TWO:   quot = prod >> 1;
                PC_THREE: quot = prod / PW'(3);
                default:  quot = prod >> 2;
            endcase
        end

        assign offsets[k*CNT_W +: CNT_W] = quot[CNT_W-1:0];
    end
endmodule

// File: rtl/pss_phase_chan.sv
module pss_phase_chan #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             active,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] len,
    input  logic [CNT_W-1:0] offset,
    input  logic [CNT_W-1:0] duty,
    output logic             pwm
);
    logic [CNT_W-1:0] local_cnt;
    logic [CNT_W-1:0] duty_max;
    logic [CNT_W-1:0] duty_eff;
    logic             at_start;
    logic             started;

    always_comb begin
        if (cnt >= offset) begin
            local_cnt = cnt - offset;
        end else begin
            local_cnt = cnt + (len - offset);
        end
        duty_max = len - CNT_W'(1);
        duty_eff = (duty > duty_max) ? duty_max : duty;
        at_start = (local_cnt == '0);
    end

    // the first period after entering RUN is gated until this phase's own start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
        end else if (!running || !active) begin
            started <= 1'b0;
        end else if (at_start) begin
            started <= 1'b1;
        end
    end

    assign pwm = running && active && (started || at_start) && (local_cnt < duty_eff);
endmodule

// File: rtl/pwm_phase_sequencer.sv
module pwm_phase_sequencer
    import pss_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [CNT_W-1:0]        period,
    input  logic [MAX_PH*CNT_W-1:0] duty,
    input  logic [SENSED-1:0]       sense_lo,
    output logic [MAX_PH-1:0]       pwm_out,
    output logic [SENSED-1:0]       pwm_probe,
    output logic                    ready,
    output logic [1:0]              phase_cnt
);
    seq_state_t              state;
    seq_state_t              state_nx;
    ph_code_t                code;
    logic [CNT_W-1:0]        len_eff;
    logic [CNT_W-1:0]        cnt;
    logic                    wrap;
    logic [MAX_PH*CNT_W-1:0] offsets;
    logic [MAX_PH-1:0]       active;
    logic                    running;

    assign len_eff = (period < CNT_W'(MIN_PERIOD)) ? CNT_W'(MIN_PERIOD) : period;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (!en) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:     state_nx = ST_PROBE_A;
                ST_PROBE_A: state_nx = ST_PROBE_B;
                ST_PROBE_B: state_nx = ST_ALIGN;
                ST_ALIGN:   state_nx = wrap ? ST_RUN : ST_ALIGN;
                ST_RUN:     state_nx = ST_RUN;
                default:    state_nx = ST_OFF;
            endcase
        end
    end

    // phase count latch, taken on the last probe cycle only
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            code <= PC_NONE;
        end else if (state == ST_PROBE_B) begin
            if (sense_lo[0]) begin
                code <= PC_TWO;
            end else if (sense_lo[1]) begin
                code <= PC_THREE;
            end else begin
                code <= PC_FOUR;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        pwm_probe = '0;
        ready     = 1'b0;
        running   = 1'b0;
        unique case (state)
            ST_OFF:     ;
            ST_PROBE_A: pwm_probe = '1;
            ST_PROBE_B: pwm_probe = '1;
            ST_ALIGN:   ready = 1'b1;
            ST_RUN: begin
                ready   = 1'b1;
                running = 1'b1;
            end
            default:    ;
        endcase
        phase_cnt = ready ? code : PC_NONE;
    end

    assign active[0] = 1'b1;
    assign active[1] = 1'b1;
    assign active[2] = (code == PC_THREE) || (code == PC_FOUR);
    assign active[3] = (code == PC_FOUR);

    pss_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state == ST_OFF),
        .len   (len_eff),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    pss_offset_gen #(.CNT_W(CNT_W)) u_off (
        .len     (len_eff),
        .code    (code),
        .offsets (offsets)
    );

    for (genvar k = 0; k < MAX_PH; k++) begin : g_chan
        pss_phase_chan #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .running (running),
            .active  (active[k]),
            .cnt     (cnt),
            .len     (len_eff),
            .offset  (offsets[k*CNT_W +: CNT_W]),
            .duty    (duty[k*CNT_W +: CNT_W]),
            .pwm     (pwm_out[k])
        );
    end
endmodule

// File: rtl/pss_checker.sv
module pss_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic [3:0] pwm_out,
    input logic [1:0] pwm_probe,
    input logic       ready,
    input logic [1:0] phase_cnt
);
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pwm_out == 4'b0 && pwm_probe == 2'b0 && !ready && phase_cnt == 2'b00)) else $error("AST_OFF_QUIET"); // R9

    AST_PROBE_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_probe != 2'b00) |-> (pwm_out == 4'b0 && !ready)) else $error("AST_PROBE_HOLDS_LOW"); // R2

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (phase_cnt != 2'b00)) else $error("AST_CODE_LEGAL"); // R3

    AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready)) |-> $stable(phase_cnt)) else $error("AST_CODE_FROZEN"); // R8

    AST_TWO_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_cnt == 2'b01) |-> (pwm_out[3:2] == 2'b00)) else $error("AST_TWO_PHASE_QUIET"); // R7

    AST_THREE_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_cnt == 2'b10) |-> !pwm_out[3]) else $error("AST_THREE_PHASE_QUIET"); // R7

    AST_READY_AFTER_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(pwm_probe == 2'b11)) else $error("AST_READY_AFTER_PROBE"); // R4

    AST_IDLE_NO_PWM: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (pwm_out == 4'b0)) else $error("AST_IDLE_NO_PWM"); // R4
endmodule

bind pwm_phase_sequencer pss_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .pwm_out   (pwm_out),
    .pwm_probe (pwm_probe),
    .ready     (ready),
    .phase_cnt (phase_cnt)
);

// File: tb/sim_pwm_phase_sequencer.sv
module sim_pwm_phase_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [CW-1:0] period = CW'(8);
    logic [4*CW-1:0] duty = '0;
    logic [1:0]    sense_lo = 2'b00;
    logic [3:0]    pwm_out;
    logic [1:0]    pwm_probe;
    logic          ready;
    logic [1:0]    phase_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [3:0] q_pwm[$];
    logic [1:0] q_probe[$];
    logic       q_ready[$];
    logic [1:0] q_code[$];
    string      q_tag_pwm[$];
    string      q_tag_ctl[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_phase_sequencer #(.CNT_W(CW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .period    (period),
        .duty      (duty),
        .sense_lo  (sense_lo),
        .pwm_out   (pwm_out),
        .pwm_probe (pwm_probe),
        .ready     (ready),
        .phase_cnt (phase_cnt)
    );

    task automatic check4(string tag, string what, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %b exp %b at %0t", tag, what, got, exp, $time);
        end
    endtask

    // monitor: pops one expected item per cycle, sampled away from the edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (q_pwm.size() > 0) begin
            logic [3:0] e_pwm;
            logic [1:0] e_probe;
            logic       e_ready;
            logic [1:0] e_code;
            string      t_pwm;
            string      t_ctl;
            e_pwm   = q_pwm.pop_front();
            e_probe = q_probe.pop_front();
            e_ready = q_ready.pop_front();
            e_code  = q_code.pop_front();
            t_pwm   = q_tag_pwm.pop_front();
            t_ctl   = q_tag_ctl.pop_front();
            check4(t_pwm, "pwm_out", pwm_out, e_pwm);
            check4(t_ctl, "pwm_probe", {2'b00, pwm_probe}, {2'b00, e_probe});
            check4(t_ctl, "ready", {3'b000, ready}, {3'b000, e_ready});
            check4(t_ctl, "phase_cnt", {2'b00, phase_cnt}, {2'b00, e_code});
        end
    end

    function automatic logic [3:0] model_pwm(int i, int pe, int n, int d0, int d1, int d2, int d3);
        int dd[4];
        logic [3:0] r;
        int c;
        int cnt;
        dd[0] = d0; dd[1] = d1; dd[2] = d2; dd[3] = d3;
        r = 4'b0;
        c = i - pe;
        cnt = c % pe;
        for (int k = 0; k < n; k++) begin
            int o;
            int loc;
            int de;
            o = (k * pe) / n;
            loc = (cnt - o + pe) % pe;
            de = (dd[k] > pe - 1) ? pe - 1 : dd[k];
            if (c >= o && loc < de) r[k] = 1'b1;
        end
        return r;
    endfunction

    task automatic push(logic [3:0] p, logic [1:0] pr, logic rd, logic [1:0] cd, string tp, string tc);
        q_pwm.push_back(p);
        q_probe.push_back(pr);
        q_ready.push_back(rd);
        q_code.push_back(cd);
        q_tag_pwm.push_back(tp);
        q_tag_ctl.push_back(tc);
    endtask

    // driver: predicts the whole case, then enables, then disables
    task automatic run_case(string tag, int per, int d0, int d1, int d2, int d3,
                            bit s3, bit s4, int run_len, bit flip);
        int pe;
        int n;
        @(negedge clk);
        period   = CW'(per);
        duty     = {CW'(d3), CW'(d2), CW'(d1), CW'(d0)};
        sense_lo = {s4, s3};
        pe = (per < 4) ? 4 : per;
        n  = s3 ? 2 : (s4 ? 3 : 4);
        for (int i = 0; i < run_len; i++) begin
            if (i < 2) begin
                push(4'b0, 2'b11, 1'b0, 2'b00, tag, "R2");
            end else if (i < pe) begin
                push(4'b0, 2'b00, 1'b1, 2'(n - 1), {tag, " R4"}, "R3 R4");
            end else begin
                push(model_pwm(i, pe, n, d0, d1, d2, d3), 2'b00, 1'b1, 2'(n - 1), tag, "R3 R8");
            end
        end
        push(4'b0, 2'b00, 1'b0, 2'b00, "R9", "R9");
        push(4'b0, 2'b00, 1'b0, 2'b00, "R9", "R9");
        en = 1'b1;
        if (flip && run_len > 3) begin
            repeat (3) @(negedge clk);
            sense_lo = ~sense_lo;
            repeat (run_len - 3) @(negedge clk);
        end else begin
            repeat (run_len) @(negedge clk);
        end
        en = 1'b0;
        while (q_pwm.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check4("R1", "pwm_out in reset", pwm_out, 4'b0);
        check4("R1", "probe/ready/cnt in reset", {pwm_probe, ready, 1'b0}, 4'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check4("R1", "pwm_out idle", pwm_out, 4'b0);
        check4("R1", "probe/ready/cnt idle", {pwm_probe, ready, 1'b0} | {2'b00, phase_cnt}, 4'b0);

        run_case("R5 R12", 20, 5, 5, 5, 5, 1'b0, 1'b0, 80, 1'b0);
        run_case("R5 R11", 16, 12, 10, 15, 9, 1'b0, 1'b0, 60, 1'b0);
        run_case("R5 R7 R8 three", 21, 7, 7, 7, 9, 1'b0, 1'b1, 70, 1'b1);
        run_case("R7 R8 two", 10, 4, 3, 9, 9, 1'b1, 1'b0, 40, 1'b1);
        run_case("R9 early drop", 12, 3, 3, 3, 3, 1'b0, 1'b0, 1, 1'b0);
        run_case("R6 clamp", 12, 0, 12, 200, 11, 1'b0, 1'b0, 40, 1'b0);
        run_case("R10 short", 2, 1, 2, 3, 1, 1'b1, 1'b1, 20, 1'b0);
        run_case("R9 reenable", 9, 8, 2, 4, 6, 1'b0, 1'b0, 30, 1'b0);

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired got running exp finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule